// File: doc/BRIEF.md
# Single-Channel Request-Paced DMA Engine

This block is one DMA channel that copies data words from a source address to a destination address over a simple synchronous memory-style master port. Each serviced request costs a read access and then a write access carrying the same data. The port is released for at least one cycle between words. The channel does not hold the port for a burst, so other masters get a slot between words.

Software, or a neighbouring block, presents the configuration and pulses `start`. The configuration holds two base addresses, a word count, an access size, one increment enable for each side, a circular option and a memory-to-memory option. A hardware request line then paces the transfer one word per pulse. In memory-to-memory mode the channel runs on its own. When a block completes, `tc_pulse` strobes and `tc_flag` is set. In circular mode the pointers and count then reload and the channel stays armed. In one-shot mode the channel goes idle. A bus error on either access halts the channel and leaves a sticky `err_flag`.

Top module: `dma_channel`

## Requirements
- R1: After reset, `bus_valid`, `busy`, `tc_pulse`, `tc_flag` and `err_flag` are all 0, and `dreq` pulses cause no bus access until a `start` with a nonzero count.
- R2: Each `dreq` pulse accepted while `busy` causes exactly one read (`bus_write`=0) at the source pointer, followed by one write (`bus_write`=1) at the destination pointer. The write carries the data returned by that read. A pulse that arrives while a word is in progress is held and served afterwards.
- R3: After the write of a word completes, `bus_valid` is 0 for at least one cycle before the next read starts.
- R4: `cfg_size` encodes 0 = byte, 1 = halfword, 2 = word, and 3 behaves as word. An enabled pointer advances by 1, 2 or 4 bytes per word. A pointer whose increment enable is 0 stays at its base address. `bus_size` carries the latched size code.
- R5: In one-shot mode, once `cfg_count` words have been moved, `busy` drops and later `dreq` pulses cause no bus access.
- R6: In circular mode, after the last word of a block both pointers and the count return to their start values, and `busy` stays 1.
- R7: `tc_pulse` is high for exactly one cycle at the end of every block, including every circular wrap. `tc_flag` is set by the same event and cleared only by `start`.
- R8: With `cfg_mem2mem`=1 the channel moves the whole block without any `dreq`.
- R9: A `bus_ready` cycle with `bus_err`=1, on either the read or the write, drops `busy`, sets `err_flag`, and stops all bus access. `err_flag` stays set until the next `start`, which clears it.
- R10: `cfg_count` is 17 bits wide, so blocks of 1 to 65,536 words are allowed. A `start` with a count of 0 leaves the channel idle.
- R11: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_write` and `bus_addr` are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch the configuration and arm; accepted while no access is in flight |
| cfg_src | input | AW | Source base address |
| cfg_dst | input | AW | Destination base address |
| cfg_count | input | CW | Words per block (1..65,536) |
| cfg_size | input | 2 | Access size code |
| cfg_src_inc | input | 1 | Source pointer increment enable |
| cfg_dst_inc | input | 1 | Destination pointer increment enable |
| cfg_circular | input | 1 | Reload at block end and stay armed |
| cfg_mem2mem | input | 1 | Run without hardware requests |
| dreq | input | 1 | Hardware request pulse, one word per pulse |
| bus_valid | output | 1 | Access in progress |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_size | output | 2 | Access size code |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Error response, qualified by bus_ready |
| busy | output | 1 | Channel armed |
| tc_pulse | output | 1 | One-cycle block-complete strobe |
| tc_flag | output | 1 | Sticky block-complete flag |
| err_flag | output | 1 | Sticky bus error flag |

## Verification
A pointer or count register that is off shows directly at the port. The address of the very next read or write is wrong, and the end-of-block strobe comes a word early or late, or fails to come at a circular wrap. A sequencer state that is off shows within one access. A back-to-back read after a write, a write with stale data, or a bus access after an error or after the last one-shot word is visible in the logged transaction stream on the cycle it happens. The directed scenarios log every completed access with its address, direction, size and data, and compare that log word by word against the expected stream.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} seq_st_t;

  // Size code to byte step: 0 -> 1, 1 -> 2, 2 and 3 -> 4
  function automatic logic [2:0] step_of(input logic [1:0] sz);
    case (sz)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [AW-1:0] base,
  input  logic          inc_en,
  input  logic [2:0]    step,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] base_q;
  logic          inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      inc_q  <= 1'b0;
      ptr    <= '0;
    end else if (arm) begin
      base_q <= base;
      inc_q  <= inc_en;
      ptr    <= base;
    end else if (wrap) begin
      ptr <= base_q;
    end else if (adv && inc_q) begin
      ptr <= ptr + AW'(step);
    end
  end

  // R6: a wrap puts the pointer back on its base
  p_wrap_base_r6: assert property (@(posedge clk) disable iff (rst)
    (wrap && !arm) |=> (ptr == base_q));
endmodule

// File: rtl/dma_cnt.sv
module dma_cnt #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [CW-1:0] init,
  input  logic          dec,
  input  logic          wrap,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      init_q <= '0;
    end else if (arm) begin
      cnt_q  <= init;
      init_q <= init;
    end else if (wrap) begin
      cnt_q <= init_q;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign last = (cnt_q == CW'(1));

  // R10: remaining words never exceed the programmed block length
  p_cnt_range_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= init_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    cfg_nonzero,
  input  logic    cfg_circ,
  input  logic    cfg_m2m,
  input  logic    dreq,
  input  logic    bus_ready,
  input  logic    bus_err,
  input  logic    last,
  output seq_st_t st,
  output logic    arm,
  output logic    rd_ok,
  output logic    adv,
  output logic    wrap,
  output logic    dec,
  output logic    active,
  output logic    tc_pulse,
  output logic    tc_flag,
  output logic    err_flag
);
  logic circ_q, m2m_q, pend_q;
  logic wr_ok, bad, blk_end, go;

  assign arm     = start && (st == ST_IDLE);
  assign rd_ok   = (st == ST_RD) && bus_ready && !bus_err;
  assign wr_ok   = (st == ST_WR) && bus_ready && !bus_err;
  assign bad     = (st != ST_IDLE) && bus_ready && bus_err;
  assign blk_end = wr_ok && last;
  assign wrap    = blk_end && circ_q;
  assign adv     = wr_ok && !wrap;
  assign dec     = wr_ok && !wrap;
  assign go      = (st == ST_IDLE) && !start && active && (pend_q || m2m_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      active   <= 1'b0;
      circ_q   <= 1'b0;
      m2m_q    <= 1'b0;
      pend_q   <= 1'b0;
      tc_pulse <= 1'b0;
      tc_flag  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      tc_pulse <= blk_end;
      if (arm) begin
        active   <= cfg_nonzero;
        circ_q   <= cfg_circ;
        m2m_q    <= cfg_m2m;
        pend_q   <= 1'b0;
        tc_flag  <= 1'b0;
        err_flag <= 1'b0;
      end else begin
        pend_q <= (pend_q && !go) || (dreq && active && !bad && !(blk_end && !circ_q));
        if (bad || (blk_end && !circ_q)) active <= 1'b0;
        if (blk_end) tc_flag <= 1'b1;
        if (bad) err_flag <= 1'b1;
      end
      case (st)
        ST_IDLE: if (go) st <= ST_RD;
        ST_RD:   if (bus_ready) st <= bus_err ? ST_IDLE : ST_WR;
        ST_WR:   if (bus_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a completed write always returns to idle for a cycle
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && bus_ready) |=> (st == ST_IDLE));
  // R9: after an error the channel is parked
  p_err_halt_r9: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (st == ST_IDLE && !active));
  // R7: the block strobe lasts one cycle
  p_tc_once_r7: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);
  // R5: one-shot block end disarms
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (blk_end && !circ_q) |=> !active);
  // R6: circular block end stays armed
  p_circ_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (blk_end && circ_q) |=> active);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic          cfg_circular,
  input  logic          cfg_mem2mem,
  input  logic          dreq,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic [1:0]    bus_size,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic          busy,
  output logic          tc_pulse,
  output logic          tc_flag,
  output logic          err_flag
);
  localparam int NSIDE = 2;  // 0 = source, 1 = destination

  seq_st_t       st;
  logic          arm, rd_ok, adv, wrap, dec, last;
  logic [1:0]    size_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] base_a [NSIDE];
  logic [AW-1:0] ptr_a  [NSIDE];
  logic          inc_a  [NSIDE];

  assign base_a[0] = cfg_src;
  assign base_a[1] = cfg_dst;
  assign inc_a[0]  = cfg_src_inc;
  assign inc_a[1]  = cfg_dst_inc;

  dma_seq u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_nonzero(cfg_count != '0), .cfg_circ(cfg_circular), .cfg_m2m(cfg_mem2mem),
    .dreq(dreq), .bus_ready(bus_ready), .bus_err(bus_err), .last(last),
    .st(st), .arm(arm), .rd_ok(rd_ok), .adv(adv), .wrap(wrap), .dec(dec),
    .active(busy), .tc_pulse(tc_pulse), .tc_flag(tc_flag), .err_flag(err_flag)
  );

  dma_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .arm(arm), .init(cfg_count),
    .dec(dec), .wrap(wrap), .last(last)
  );

  for (genvar i = 0; i < NSIDE; i++) begin : g_ptr
    dma_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst(rst), .arm(arm), .base(base_a[i]), .inc_en(inc_a[i]),
      .step(step_of(size_q)), .adv(adv), .wrap(wrap), .ptr(ptr_a[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= 2'd0;
      data_q <= '0;
    end else begin
      if (arm)   size_q <= cfg_size;
      if (rd_ok) data_q <= bus_rdata;
    end
  end

  assign bus_valid = (st != ST_IDLE);
  assign bus_write = (st == ST_WR);
  assign bus_addr  = bus_write ? ptr_a[1] : ptr_a[0];
  assign bus_wdata = data_q;
  assign bus_size  = size_q;

  // R11: a stalled access holds its address and direction
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));
  // R2: the write carries what the preceding read returned
  p_wdata_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_write) |-> (bus_wdata == $past(bus_rdata)));
endmodule

// File: tb/dma_channel_tb.sv
module dma_channel_tb;
  localparam int AW = 32, DW = 32, CW = 17;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, dreq = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0] cfg_size = '0;
  logic cfg_src_inc = 0, cfg_dst_inc = 0, cfg_circular = 0, cfg_mem2mem = 0;
  logic bus_valid, bus_write, busy, tc_pulse, tc_flag, err_flag;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic [1:0] bus_size;
  logic bus_ready = 1'b0, bus_err = 1'b0;

  always #5 clk = ~clk;

  dma_channel #(.AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

  int n_chk = 0, n_fail = 0, waits = 0, err_idx = -1, ntr = 0, tc_cnt = 0, gap_viol = 0, wcnt = 0;
  bit prev_wr = 0, done = 0;
  logic [AW-1:0] tr_addr [64];
  logic [DW-1:0] tr_data [64];
  logic          tr_we   [64];
  logic [1:0]    tr_sz   [64];

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  // slave model and transaction logger, all on the falling edge
  initial forever begin
    @(negedge clk);
    if (rst) begin
      bus_ready = 0; bus_err = 0; wcnt = 0; prev_wr = 0;
    end else begin
      if (prev_wr && bus_valid) gap_viol++;
      if (tc_pulse) tc_cnt++;
      prev_wr = 0;
      if (bus_valid) begin
        bus_rdata = mem_rd(bus_addr);
        if (wcnt == waits) begin
          bus_ready = 1; bus_err = (ntr == err_idx);
          if (ntr < 64) begin
            tr_addr[ntr] = bus_addr; tr_data[ntr] = bus_wdata;
            tr_we[ntr] = bus_write; tr_sz[ntr] = bus_size;
          end
          ntr++; wcnt = 0; prev_wr = bus_write;
        end else begin
          bus_ready = 0; bus_err = 0; wcnt++;
        end
      end else begin
        bus_ready = 0; bus_err = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [AW-1:0] s, input logic [AW-1:0] d, input int cnt,
                     input logic [1:0] sz, input bit si, input bit di, input bit circ, input bit m2m);
    @(negedge clk);
    ntr = 0; tc_cnt = 0; gap_viol = 0;
    cfg_src = s; cfg_dst = d; cfg_count = CW'(cnt); cfg_size = sz;
    cfg_src_inc = si; cfg_dst_inc = di; cfg_circular = circ; cfg_mem2mem = m2m;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_req();
    dreq = 1; @(negedge clk); dreq = 0;
  endtask

  task automatic t_reset();
    chk("R1 bus_valid after reset", bus_valid, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 flags after reset", {tc_pulse, tc_flag, err_flag}, 0);
    ntr = 0;
    pulse_req(); idle(8);
    chk("R1 request before start ignored", ntr, 0);
  endtask

  task automatic t_p2m();
    logic [AW-1:0] s = 32'h4000_0010, d = 32'h2000_0100;
    arm(s, d, 3, 2'd1, 0, 1, 0, 0);
    idle(5);
    chk("R2 no access without request", ntr, 0);
    for (int i = 0; i < 3; i++) begin pulse_req(); idle(10); end
    chk("R2 access count", ntr, 6);
    for (int i = 0; i < 3; i++) begin
      chk("R2 read direction", tr_we[2*i], 0);
      chk("R4 fixed source address", tr_addr[2*i], s);
      chk("R2 write direction", tr_we[2*i+1], 1);
      chk("R4 halfword destination step", tr_addr[2*i+1], d + 2*i);
      chk("R2 write data", tr_data[2*i+1], mem_rd(s));
      chk("R4 bus_size halfword", tr_sz[2*i+1], 2'd1);
    end
    chk("R5 busy drops", busy, 0);
    chk("R7 tc_flag set", tc_flag, 1);
    chk("R7 one strobe", tc_cnt, 1);
    pulse_req(); idle(10);
    chk("R5 request after block ignored", ntr, 6);
  endtask

  task automatic t_circ();
    logic [AW-1:0] s = 32'h0000_1000, d = 32'h0000_3000;
    arm(s, d, 2, 2'd2, 1, 1, 1, 0);
    for (int i = 0; i < 5; i++) begin pulse_req(); idle(8); end
    chk("R6 access count", ntr, 10);
    for (int i = 0; i < 5; i++) begin
      chk("R6 read address after reload", tr_addr[2*i], s + 4*(i%2));
      chk("R6 write address after reload", tr_addr[2*i+1], d + 4*(i%2));
    end
    chk("R7 strobe at each wrap", tc_cnt, 2);
    chk("R6 busy held", busy, 1);
    chk("R7 tc_flag sticky", tc_flag, 1);
  endtask

  task automatic t_m2m();
    logic [AW-1:0] s = 32'h0000_0500, d = 32'h0000_0600;
    arm(s, d, 4, 2'd0, 1, 1, 0, 1);
    chk("R7 tc_flag cleared by start", tc_flag, 0);
    idle(30);
    chk("R8 free-running access count", ntr, 8);
    for (int i = 0; i < 4; i++) begin
      chk("R4 byte source step", tr_addr[2*i], s + i);
      chk("R4 byte destination step", tr_addr[2*i+1], d + i);
      chk("R8 write data", tr_data[2*i+1], mem_rd(s + i));
    end
    chk("R3 idle cycle between words", gap_viol, 0);
    chk("R8 done", {busy, tc_flag}, 2'b01);
  endtask

  task automatic t_waits();
    logic [AW-1:0] s = 32'h4000_0020, d = 32'h2000_0000;
    waits = 2;
    arm(s, d, 2, 2'd3, 0, 1, 0, 0);
    pulse_req(); pulse_req();  // second held while first in progress
    idle(30);
    chk("R2 held request served", ntr, 4);
    chk("R11 stalled read address", tr_addr[0], s);
    chk("R4 reserved size steps 4", tr_addr[3], d + 4);
    chk("R11 stalled write data", tr_data[3], mem_rd(s));
    chk("R3 gap with wait states", gap_viol, 0);
    waits = 0;
  endtask

  task automatic t_err();
    err_idx = 3;
    arm(32'h100, 32'h200, 4, 2'd2, 1, 1, 0, 1);
    idle(30);
    chk("R9 write error stops transfer", ntr, 4);
    chk("R9 state after write error", {busy, err_flag, tc_flag}, 3'b010);
    err_idx = -1;
    arm(32'h100, 32'h200, 1, 2'd2, 1, 1, 0, 1);
    idle(10);
    chk("R9 start clears error", {err_flag, tc_flag}, 2'b01);
    err_idx = 0;
    arm(32'h100, 32'h200, 4, 2'd2, 1, 1, 0, 1);
    idle(20);
    chk("R9 read error stops transfer", ntr, 1);
    chk("R9 state after read error", {busy, err_flag}, 2'b01);
    err_idx = -1;
  endtask

  task automatic t_zero();
    arm(32'h100, 32'h200, 0, 2'd2, 1, 1, 0, 0);
    idle(2);
    chk("R10 zero count stays idle", busy, 0);
    pulse_req(); idle(8);
    chk("R10 zero count no access", ntr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_p2m(); t_circ(); t_m2m(); t_waits(); t_err(); t_zero();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule